// File: doc/BRIEF.md
# Configurable Dual-Structure LFSR Generator

This block is a linear feedback shift register that produces a pseudo-random bit stream. Parameters fix everything at elaboration: the register width, the set of tap positions, the starting value, whether each feedback gate is XOR or XNOR, and how the feedback is built. In the many-to-one form, one wide gate combines all tapped bits into the new LSB. In the one-to-many form, the MSB is fed back and two-input gates sit between selected stages. For the same taps and seed, the two forms give different sequences.

On every enabled clock edge the register moves one step toward the MSB, and the new bit enters at the LSB end. A synchronous reset reloads the seed and takes priority over the enable. The serial output always shows the current MSB. When a parameter turns it on, a parallel output shows the whole register as an unsigned number. The seed parameter may be wider than the register; its extra high bits are dropped. A tap set with fewer than two taps is refused at elaboration, and so is a seed that would lock the register.

Top module: `lfsr_gen`

## Requirements
- R1: A high `rst` sampled at a rising edge of `clk` loads the seed (truncated to `WIDTH`) into the register, whatever `en` is.
- R2: With `rst` low and `en` low at a rising edge, the register keeps its value.
- R3: In the many-to-one form (`ONE_TO_MANY`=0), each enabled step moves bit i to bit i+1. The new bit 0 is the XOR of all tapped bits. Tap position t (1 = LSB, `WIDTH` = MSB) is register bit t-1 and is bit t-1 of `TAPS`.
- R4: In the one-to-many form (`ONE_TO_MANY`=1), each enabled step loads the old MSB into bit 0. Each bit j ≥ 1 takes old bit j-1. Where position `WIDTH`-j is a tap, that value first passes through a two-input gate together with the old MSB.
- R5: With `USE_XNOR`=1, every feedback gate in either form gives the inverse of its XOR result.
- R6: `serOut` equals the current register MSB at all times.
- R7: When `HAS_PAR`=1, `parOut` equals the register contents. When `HAS_PAR`=0, `parOut` is all zeros.
- R8: Seed bits at positions `WIDTH` and above are dropped. A 5-bit register with seed 'h7E2 restarts at 5'h02.
- R9: Fewer than two taps, or a lock-up seed (all zeros with XOR, all ones with XNOR), is refused at elaboration. A legal setup never reaches the lock-up value.
- R10: For a primitive tap set, the register visits 2^`WIDTH`-1 distinct states in one period and then returns to the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reload of the seed, overrides `en` |
| en | input | 1 | Step enable; low holds the register |
| serOut | output | 1 | Current register MSB |
| parOut | output | WIDTH | Whole register as an unsigned value, or zero when disabled |

## Verification
There is exactly one register between the control inputs and both outputs. A reset or a step applied at a rising edge therefore shows up in `serOut` and `parOut` right after that edge, and the previous value stays visible until then. The bench changes `rst` and `en` only at falling edges and advances its behavioural model at the rising edge. It compares every output at the following falling edge, so each result is checked in the cycle it falls due. The period count and the hold check use the same sampling point, which makes a step that arrives one cycle early or late show up as a mismatch.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  // strobes from the control half to the register half
  typedef struct packed {
    logic load;   // reload the seed
    logic step;   // advance one position
  } lfsrStrobe_t;

  // number of set bits in a tap mask, usable in constant expressions
  function automatic int countTaps(input logic [63:0] mask);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (mask[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_pkg::*;
(
  input  logic        rst,
  input  logic        en,
  output lfsrStrobe_t strobes
);

  // reset wins over enable
  always_comb begin
    strobes.load = rst;
    strobes.step = en & ~rst;
  end

endmodule

// File: rtl/lfsr_core.sv
module lfsr_core
  import lfsr_pkg::*;
#(
  parameter int              WIDTH       = 8,
  parameter logic [WIDTH-1:0] TAPS       = 8'hB8,
  parameter logic [63:0]     SEED        = 64'h1,
  parameter bit              USE_XNOR    = 1'b0,
  parameter bit              ONE_TO_MANY = 1'b0
) (
  input  logic             clk,
  input  lfsrStrobe_t      strobes,
  output logic [WIDTH-1:0] state
);

  localparam logic [WIDTH-1:0] SEED_T   = SEED[WIDTH-1:0];
  localparam logic             INV_BIT  = USE_XNOR;
  localparam logic [WIDTH-1:0] LOCK_VAL = USE_XNOR ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] stateNxt;

  generate
    if (ONE_TO_MANY == 1'b0) begin : gen_manyToOne
      logic feedBit;
      assign feedBit  = (^(stateQ & TAPS)) ^ INV_BIT;
      assign stateNxt = {stateQ[WIDTH-2:0], feedBit};
    end else begin : gen_oneToMany
      assign stateNxt[0] = stateQ[WIDTH-1];
      for (genvar j = 1; j < WIDTH; j++) begin : gen_stage
        if (TAPS[WIDTH-1-j]) begin : gen_gate
          assign stateNxt[j] = stateQ[j-1] ^ stateQ[WIDTH-1] ^ INV_BIT;
        end else begin : gen_pass
          assign stateNxt[j] = stateQ[j-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.load)      stateQ <= SEED_T;
    else if (strobes.step) stateQ <= stateNxt;
  end

  assign state = stateQ;

  // seed lands one edge after the load strobe
  assert_reset_seed_R1: assert property (@(posedge clk)
    strobes.load |=> stateQ == SEED_T);

  assert_hold_R2: assert property (@(posedge clk) disable iff (strobes.load)
    !strobes.step |=> $stable(stateQ));

  assert_no_lockup_R9: assert property (@(posedge clk) disable iff (strobes.load)
    stateQ != LOCK_VAL);

  generate
    if (ONE_TO_MANY == 1'b0) begin : gen_chkFib
      assert_fib_shift_R3: assert property (@(posedge clk) disable iff (strobes.load)
        strobes.step |=> stateQ[WIDTH-1:1] == $past(stateQ[WIDTH-2:0]));
    end else begin : gen_chkGal
      assert_gal_wrap_R4: assert property (@(posedge clk) disable iff (strobes.load)
        strobes.step |=> stateQ[0] == $past(stateQ[WIDTH-1]));
    end
  endgenerate

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
  import lfsr_pkg::*;
#(
  parameter int              WIDTH       = 8,
  parameter logic [WIDTH-1:0] TAPS       = 8'hB8,
  parameter logic [63:0]     SEED        = 64'h1,
  parameter bit              USE_XNOR    = 1'b0,
  parameter bit              ONE_TO_MANY = 1'b0,
  parameter bit              HAS_PAR     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             serOut,
  output logic [WIDTH-1:0] parOut
);

  localparam int          TAP_COUNT = countTaps(64'(TAPS));
  localparam logic [WIDTH-1:0] SEED_T = SEED[WIDTH-1:0];
  localparam bit          SEED_LOCKS = USE_XNOR ? (SEED_T == {WIDTH{1'b1}})
                                                : (SEED_T == {WIDTH{1'b0}});

  // elaboration-time refusals (R9)
  generate
    if (WIDTH < 2 || WIDTH > 64) begin : assert_width_range_R9
      $error("lfsr_gen: WIDTH must lie in 2..64");
    end
    if (TAP_COUNT < 2) begin : assert_min_taps_R9
      $error("lfsr_gen: at least two taps are needed");
    end
    if (SEED_LOCKS) begin : assert_seed_lockup_R9
      $error("lfsr_gen: seed equals the lock-up value for this gate type");
    end
  endgenerate

  lfsrStrobe_t      strobes;
  logic [WIDTH-1:0] state;

  lfsr_ctrl ctrl_i (
    .rst     (rst),
    .en      (en),
    .strobes (strobes)
  );

  lfsr_core #(
    .WIDTH       (WIDTH),
    .TAPS        (TAPS),
    .SEED        (SEED),
    .USE_XNOR    (USE_XNOR),
    .ONE_TO_MANY (ONE_TO_MANY)
  ) core_i (
    .clk     (clk),
    .strobes (strobes),
    .state   (state)
  );

  assign serOut = state[WIDTH-1];

  generate
    if (HAS_PAR) begin : gen_par
      assign parOut = state;
    end else begin : gen_noPar
      assign parOut = '0;
    end
  endgenerate

endmodule

// File: tb/lfsr_gen_tb_top.sv
module lfsr_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       serA, serB, serC, serD;
  logic [7:0] parA, parB, parC;
  logic [4:0] parD;

  // A: many-to-one XOR, B: one-to-many XNOR, C: many-to-one XNOR, D: 5-bit oversized seed, no parallel
  lfsr_gen #(.WIDTH(8), .TAPS(8'hB8), .SEED(64'h01), .USE_XNOR(1'b0), .ONE_TO_MANY(1'b0), .HAS_PAR(1'b1))
    dut_i (.clk(clk), .rst(rst), .en(en), .serOut(serA), .parOut(parA));
  lfsr_gen #(.WIDTH(8), .TAPS(8'hB8), .SEED(64'h3C), .USE_XNOR(1'b1), .ONE_TO_MANY(1'b1), .HAS_PAR(1'b1))
    dutGal_i (.clk(clk), .rst(rst), .en(en), .serOut(serB), .parOut(parB));
  lfsr_gen #(.WIDTH(8), .TAPS(8'hB8), .SEED(64'h00), .USE_XNOR(1'b1), .ONE_TO_MANY(1'b0), .HAS_PAR(1'b1))
    dutFx_i (.clk(clk), .rst(rst), .en(en), .serOut(serC), .parOut(parC));
  lfsr_gen #(.WIDTH(5), .TAPS(5'h14), .SEED(64'h7E2), .USE_XNOR(1'b0), .ONE_TO_MANY(1'b0), .HAS_PAR(1'b0))
    dutTrunc_i (.clk(clk), .rst(rst), .en(en), .serOut(serD), .parOut(parD));

  // behavioural reference models
  logic [63:0] mA, mB, mC, mD;

  function automatic logic [63:0] stepModel(input logic [63:0] s, input int w, input bit gal,
                                            input bit xn, input logic [63:0] taps);
    logic [63:0] mask, r;
    logic msb, fb;
    mask = (64'd1 << w) - 64'd1;
    msb  = s[w-1];
    if (!gal) begin
      fb = 1'b0;
      for (int t = 1; t <= w; t++) if (taps[t-1]) fb = fb ^ s[t-1];
      if (xn) fb = ~fb;
      r = ((s << 1) | {63'd0, fb}) & mask;
    end else begin
      r = (s << 1) & mask;
      r[0] = msb;
      for (int t = 1; t < w; t++) begin
        if (taps[t-1]) r[w-t] = xn ? ~(s[w-t-1] ^ msb) : (s[w-t-1] ^ msb);
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(parA == mA[7:0], "R3 many-to-one XOR", 64'(parA), mA);
    check(parB == mB[7:0], "R4 R5 one-to-many XNOR", 64'(parB), mB);
    check(parC == mC[7:0], "R5 many-to-one XNOR", 64'(parC), mC);
    check(serA == mA[7] && serB == mB[7] && serC == mC[7], "R6 serial MSB",
          64'({serA, serB, serC}), 64'({mA[7], mB[7], mC[7]}));
    check(serD == mD[4], "R8 truncated seed sequence", 64'(serD), 64'(mD[4]));
    check(parD == 5'd0, "R7 parallel disabled", 64'(parD), 64'd0);
    check(parA != 8'h00 && parB != 8'hFF && parC != 8'hFF, "R9 no lock-up",
          64'({parA, parB, parC}), 64'd0);
  endtask

  // drive for the coming rising edge, update the model there, compare at the falling edge
  task automatic tick(input bit r, input bit e);
    rst = r;
    en  = e;
    @(posedge clk);
    if (r) begin
      mA = 64'h01; mB = 64'h3C; mC = 64'h00; mD = 64'h02;
    end else if (e) begin
      mA = stepModel(mA, 8, 1'b0, 1'b0, 64'hB8);
      mB = stepModel(mB, 8, 1'b1, 1'b1, 64'hB8);
      mC = stepModel(mC, 8, 1'b0, 1'b1, 64'hB8);
      mD = stepModel(mD, 5, 1'b0, 1'b0, 64'h14);
    end
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    bit seenA [256];
    bit seenB [256];
    logic [7:0] holdA;
    bit repA, repB;
    mA = '0; mB = '0; mC = '0; mD = '0;

    // R1 reset state, with enable high to show priority
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    check(parA == 8'h01 && parB == 8'h3C && parC == 8'h00, "R1 reset value",
          64'({parA, parB, parC}), 64'h01_3C_00);
    check(serD == 1'b0, "R8 seed 7E2 truncated to 02 (MSB 0)", 64'(serD), 64'd0);

    // R10 full period on the primitive tap set
    repA = 1'b0; repB = 1'b0;
    seenA[8'h01] = 1'b1; seenB[8'h3C] = 1'b1;
    for (int i = 0; i < 255; i++) begin
      tick(1'b0, 1'b1);
      if (i < 254) begin
        if (seenA[parA]) repA = 1'b1;
        if (seenB[parB]) repB = 1'b1;
        seenA[parA] = 1'b1; seenB[parB] = 1'b1;
      end
    end
    check(!repA && !repB, "R10 no repeated state in one period", 64'({repA, repB}), 64'd0);
    check(parA == 8'h01 && parB == 8'h3C, "R10 period 255 returns to seed",
          64'({parA, parB}), 64'h01_3C);

    // R2 hold while enable is low
    tick(1'b0, 1'b1);
    holdA = parA;
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
    check(parA == holdA, "R2 hold with enable low", 64'(parA), 64'(holdA));

    // mixed enable pattern with a reset that overrides enable
    for (int i = 0; i < 60; i++) begin
      if (i == 40) tick(1'b1, 1'b1);
      else         tick(1'b0, (i % 3) != 0);
    end
    check(1'b1, "R1 mid-run reset covered by model", 64'd0, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule